// File: doc/BRIEF.md
# AXI4-Lite Request Sequencer

This block sits between simple user logic and an AXI4-Lite register slave, acting as the bus master. The user raises a one-cycle read or write request together with an address, write data and byte strobes. The block turns that request into exactly one AXI4-Lite transaction. It drives the write-address, write-data and read-address channels and accepts the write-response and read-data channels.

When the response comes back, the block returns the read data, a one-cycle completion pulse and separate read and write error flags. Only one transaction is ever in flight. A new request is taken only while the controller is idle.

Internally a four-state controller (idle, write, read, acknowledge) steps through each transfer. The request fields are latched when a request is taken, so the user may change them freely afterwards. When both request lines are high in the same idle cycle, the read wins.

Top module: `axil_req_master`

## Requirements
- R1: While `rst_n` is low at a rising clock edge (synchronous, active-low reset), the block returns to idle. After that edge `m_awvalid`, `m_wvalid`, `m_arvalid`, `m_bready`, `m_rready`, `done`, `rd_err` and `wr_err` are all 0, and `rd_data` is 0.
- R2: Read has priority. If `req_rd` and `req_wr` are both high in an idle cycle, only a read-address transfer is issued and no write-address or write-data transfer happens.
- R3: For a write, `m_awvalid` and `m_wvalid` rise in the cycle after the request is taken. They carry the latched address, data and strobes (one strobe bit per byte lane). Each valid stays high, with stable payload, until its own ready is seen, and then drops on its own regardless of the other channel.
- R4: `m_bready` is high for the whole write phase. The write ends on the cycle where `m_bvalid` and `m_bready` are both high. `done` is high for exactly the single cycle after that handshake.
- R5: For a read, `m_arvalid` carries the latched address until `m_arready` is seen, and `m_rready` is high for the whole read phase. `rd_data` captures `m_rdata` on the `m_rvalid`/`m_rready` handshake and holds it until the next read handshake.
- R6: Response codes are 2'b00 OKAY, 2'b01 EXOKAY, 2'b10 SLVERR and 2'b11 DECERR. A write response of SLVERR sets `wr_err`, and a read response of SLVERR sets `rd_err`. Both flags are valid in the `done` cycle.
- R7: With `DECERR_IS_ERR` = 1 (the default), DECERR sets the same flag as SLVERR. OKAY and EXOKAY leave the flags at 0.
- R8: The error flags hold their value until the next request is taken. Both flags are 0 in the cycle after any request is taken.
- R9: Requests raised while the controller is busy, including the acknowledge cycle, are ignored. Changes to `req_addr`, `req_wdata` or `req_wstrb` after a request is taken do not alter the transaction. Exactly one AXI transaction is issued per accepted request.
- R10: After `done`, the controller is idle in the next cycle and takes a new request raised then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_rd | input | 1 | Read request, sampled in idle |
| req_wr | input | 1 | Write request, sampled in idle |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| req_wstrb | input | DATA_W/8 | Byte strobes for the write |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Last captured read data |
| rd_err | output | 1 | Read error flag, sticky until next request |
| wr_err | output | 1 | Write error flag, sticky until next request |
| m_awaddr | output | ADDR_W | Write address |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Write strobes |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response code |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_araddr | output | ADDR_W | Read address |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | DATA_W | Read data |
| m_rresp | input | 2 | Read response code |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |

## Verification
A request taken at one rising edge shows its channel valids, and its cleared error flags, after that same edge, so they are visible one cycle after the request is raised. `done`, the captured read data and the error flags all appear after the edge that completes the response handshake, and `done` falls one edge later. The bench drives and samples only on falling edges. It waits for `done` and compares the queued expectation in exactly that cycle. It checks that the controller is idle on the following falling edge, which is where a back-to-back request is raised.

// File: rtl/axil_req_pkg.sv
package axil_req_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_WRITE = 2'd1,
      SEQ_READ  = 2'd2,
      SEQ_ACK   = 2'd3
   } seq_state_e;

   localparam logic [1:0] RESP_OKAY   = 2'b00;
   localparam logic [1:0] RESP_EXOKAY = 2'b01;
   localparam logic [1:0] RESP_SLVERR = 2'b10;
   localparam logic [1:0] RESP_DECERR = 2'b11;

endpackage

// File: rtl/axil_req_fsm.sv
module axil_req_fsm
   import axil_req_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_rd,
   input  logic       req_wr,
   input  logic       b_fire,
   input  logic       r_fire,
   output seq_state_e state,
   output logic       take_rd,
   output logic       take_wr
);

   seq_state_e state_nx;

   // read request wins over write in idle
   assign take_rd = (state == SEQ_IDLE) && req_rd;
   assign take_wr = (state == SEQ_IDLE) && !req_rd && req_wr;

   always_comb begin
      state_nx = state;
      case (state)
         SEQ_IDLE: begin
            if (take_rd)      state_nx = SEQ_READ;
            else if (take_wr) state_nx = SEQ_WRITE;
         end
         SEQ_WRITE: if (b_fire) state_nx = SEQ_ACK;
         SEQ_READ:  if (r_fire) state_nx = SEQ_ACK;
         SEQ_ACK:   state_nx = SEQ_IDLE;
         default:   state_nx = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= SEQ_IDLE;
      else        state <= state_nx;
   end

   p_ack_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_ACK) |=> (state == SEQ_IDLE));

   p_read_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_IDLE && req_rd) |=> (state == SEQ_READ));

   p_write_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_WRITE && !b_fire) |=> (state == SEQ_WRITE));

   p_read_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_READ && !r_fire) |=> (state == SEQ_READ));

endmodule

// File: rtl/axil_req_wr_chan.sv
module axil_req_wr_chan #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int STRB_W = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              active,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] data_in,
   input  logic [STRB_W-1:0] strb_in,
   output logic [ADDR_W-1:0] awaddr,
   output logic              awvalid,
   input  logic              awready,
   output logic [DATA_W-1:0] wdata,
   output logic [STRB_W-1:0] wstrb,
   output logic              wvalid,
   input  logic              wready
);

   logic aw_sent;
   logic w_sent;

   assign awvalid = active && !aw_sent;
   assign wvalid  = active && !w_sent;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         awaddr  <= '0;
         wdata   <= '0;
         wstrb   <= '0;
         aw_sent <= 1'b0;
         w_sent  <= 1'b0;
      end else if (load) begin
         awaddr  <= addr_in;
         wdata   <= data_in;
         wstrb   <= strb_in;
         aw_sent <= 1'b0;
         w_sent  <= 1'b0;
      end else begin
         if (awvalid && awready) aw_sent <= 1'b1;
         if (wvalid && wready)   w_sent  <= 1'b1;
      end
   end

   p_aw_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (awvalid && !awready) |=> (awvalid && $stable(awaddr)));

   p_aw_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (awvalid && awready) |=> !awvalid);

   p_w_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wvalid && !wready) |=> (wvalid && $stable(wdata) && $stable(wstrb)));

   p_w_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wvalid && wready) |=> !wvalid);

endmodule

// File: rtl/axil_req_rd_chan.sv
module axil_req_rd_chan #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              active,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] araddr,
   output logic              arvalid,
   input  logic              arready
);

   logic ar_sent;

   assign arvalid = active && !ar_sent;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         araddr  <= '0;
         ar_sent <= 1'b0;
      end else if (load) begin
         araddr  <= addr_in;
         ar_sent <= 1'b0;
      end else if (arvalid && arready) begin
         ar_sent <= 1'b1;
      end
   end

   p_ar_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (arvalid && !arready) |=> (arvalid && $stable(araddr)));

   p_ar_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (arvalid && arready) |=> !arvalid);

endmodule

// File: rtl/axil_req_result.sv
module axil_req_result
   import axil_req_pkg::*;
#(
   parameter int DATA_W        = 32,
   parameter bit DECERR_IS_ERR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              b_fire,
   input  logic [1:0]        bresp,
   input  logic              r_fire,
   input  logic [1:0]        rresp,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_err,
   output logic              wr_err
);

   logic b_bad;
   logic r_bad;

   if (DECERR_IS_ERR) begin : g_any_fault
      assign b_bad = (bresp == RESP_SLVERR) || (bresp == RESP_DECERR);
      assign r_bad = (rresp == RESP_SLVERR) || (rresp == RESP_DECERR);
   end else begin : g_slave_fault_only
      assign b_bad = (bresp == RESP_SLVERR);
      assign r_bad = (rresp == RESP_SLVERR);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data <= '0;
         rd_err  <= 1'b0;
         wr_err  <= 1'b0;
      end else begin
         if (clr) begin
            rd_err <= 1'b0;
            wr_err <= 1'b0;
         end
         if (b_fire) wr_err <= b_bad;
         if (r_fire) begin
            rd_data <= rdata;
            rd_err  <= r_bad;
         end
      end
   end

   p_wr_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !b_fire) |=> $stable(wr_err));

   p_rd_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !r_fire) |=> $stable(rd_err));

   p_clear_on_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!rd_err && !wr_err));

   p_rdata_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !r_fire |=> $stable(rd_data));

endmodule

// File: rtl/axil_req_master.sv
module axil_req_master
   import axil_req_pkg::*;
#(
   parameter int ADDR_W        = 32,
   parameter int DATA_W        = 32,
   parameter bit DECERR_IS_ERR = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_rd,
   input  logic                  req_wr,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [DATA_W-1:0]     req_wdata,
   input  logic [DATA_W/8-1:0]   req_wstrb,
   output logic                  done,
   output logic [DATA_W-1:0]     rd_data,
   output logic                  rd_err,
   output logic                  wr_err,
   output logic [ADDR_W-1:0]     m_awaddr,
   output logic                  m_awvalid,
   input  logic                  m_awready,
   output logic [DATA_W-1:0]     m_wdata,
   output logic [DATA_W/8-1:0]   m_wstrb,
   output logic                  m_wvalid,
   input  logic                  m_wready,
   input  logic [1:0]            m_bresp,
   input  logic                  m_bvalid,
   output logic                  m_bready,
   output logic [ADDR_W-1:0]     m_araddr,
   output logic                  m_arvalid,
   input  logic                  m_arready,
   input  logic [DATA_W-1:0]     m_rdata,
   input  logic [1:0]            m_rresp,
   input  logic                  m_rvalid,
   output logic                  m_rready
);

   localparam int STRB_W = DATA_W / 8;

   if (ADDR_W < 1) begin : g_bad_addr_w
      $error("axil_req_master: ADDR_W must be at least 1");
   end
   if ((DATA_W < 8) || (DATA_W % 8 != 0)) begin : g_bad_data_w
      $error("axil_req_master: DATA_W must be a positive multiple of 8");
   end

   seq_state_e state;
   logic       take_rd;
   logic       take_wr;
   logic       b_fire;
   logic       r_fire;

   assign m_bready = (state == SEQ_WRITE);
   assign m_rready = (state == SEQ_READ);
   assign done     = (state == SEQ_ACK);
   assign b_fire   = m_bvalid && m_bready;
   assign r_fire   = m_rvalid && m_rready;

   axil_req_fsm u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_rd  (req_rd),
      .req_wr  (req_wr),
      .b_fire  (b_fire),
      .r_fire  (r_fire),
      .state   (state),
      .take_rd (take_rd),
      .take_wr (take_wr)
   );

   axil_req_wr_chan #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .STRB_W (STRB_W)
   ) u_wr_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (take_wr),
      .active  (state == SEQ_WRITE),
      .addr_in (req_addr),
      .data_in (req_wdata),
      .strb_in (req_wstrb),
      .awaddr  (m_awaddr),
      .awvalid (m_awvalid),
      .awready (m_awready),
      .wdata   (m_wdata),
      .wstrb   (m_wstrb),
      .wvalid  (m_wvalid),
      .wready  (m_wready)
   );

   axil_req_rd_chan #(
      .ADDR_W (ADDR_W)
   ) u_rd_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (take_rd),
      .active  (state == SEQ_READ),
      .addr_in (req_addr),
      .araddr  (m_araddr),
      .arvalid (m_arvalid),
      .arready (m_arready)
   );

   axil_req_result #(
      .DATA_W        (DATA_W),
      .DECERR_IS_ERR (DECERR_IS_ERR)
   ) u_result (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (take_rd || take_wr),
      .b_fire  (b_fire),
      .bresp   (m_bresp),
      .r_fire  (r_fire),
      .rresp   (m_rresp),
      .rdata   (m_rdata),
      .rd_data (rd_data),
      .rd_err  (rd_err),
      .wr_err  (wr_err)
   );

   p_one_direction_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(m_arvalid && (m_awvalid || m_wvalid)));

   p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_after_resp_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (b_fire || r_fire) |=> done);

endmodule

// File: tb/axil_req_master_bench.sv
module axil_req_master_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_rd, req_wr;
   logic [31:0] req_addr, req_wdata;
   logic [3:0]  req_wstrb;
   logic        done, rd_err, wr_err;
   logic [31:0] rd_data;
   logic [31:0] m_awaddr, m_wdata, m_araddr;
   logic [3:0]  m_wstrb;
   logic        m_awvalid, m_wvalid, m_arvalid, m_bready, m_rready;
   logic        s_awready, s_wready, s_arready, s_bvalid, s_rvalid;
   logic [1:0]  s_bresp, s_rresp;
   logic [31:0] s_rdata;

   always #4 clk = ~clk;

   axil_req_master u_axil_req_master (
      .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_wstrb(req_wstrb),
      .done(done), .rd_data(rd_data), .rd_err(rd_err), .wr_err(wr_err),
      .m_awaddr(m_awaddr), .m_awvalid(m_awvalid), .m_awready(s_awready),
      .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wvalid(m_wvalid), .m_wready(s_wready),
      .m_bresp(s_bresp), .m_bvalid(s_bvalid), .m_bready(m_bready),
      .m_araddr(m_araddr), .m_arvalid(m_arvalid), .m_arready(s_arready),
      .m_rdata(s_rdata), .m_rresp(s_rresp), .m_rvalid(s_rvalid), .m_rready(m_rready)
   );

   typedef struct {
      bit          is_rd;
      logic [31:0] data;
      bit          err;
      logic [1:0]  resp;
   } exp_t;

   exp_t exp_q[$];
   int   n_cmp = 0;
   int   n_bad = 0;

   // slave model settings, written by the driver
   int          lat_aw, lat_w, lat_b, lat_r;
   logic [1:0]  cfg_resp;
   logic [31:0] cfg_rdata, exp_addr, exp_wdata;
   logic [3:0]  exp_strb;
   int          n_aw = 0, n_w = 0, n_ar = 0;

   task automatic chk_bit(input string rq, input string what, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%b expected=%b", rq, what, act, exp);
      end
   endtask

   task automatic chk_word(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   task automatic chk_int(input string rq, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
      end
   endtask

   // AXI4-Lite slave model: decisions at falling edges, handshakes retired one edge later
   initial begin
      int aw_wait, w_wait, b_wait, ar_wait, r_wait;
      bit aw_fire, w_fire, b_fire, ar_fire, r_fire, got_aw, got_w, got_ar;
      aw_wait = 0; w_wait = 0; b_wait = 0; ar_wait = 0; r_wait = 0;
      aw_fire = 0; w_fire = 0; b_fire = 0; ar_fire = 0; r_fire = 0;
      got_aw = 0; got_w = 0; got_ar = 0;
      s_awready = 0; s_wready = 0; s_arready = 0; s_bvalid = 0; s_rvalid = 0;
      s_bresp = 2'b00; s_rresp = 2'b00; s_rdata = '0;
      forever begin
         @(negedge clk);
         if (!rst_n) begin
            aw_fire = 0; w_fire = 0; b_fire = 0; ar_fire = 0; r_fire = 0;
            got_aw = 0; got_w = 0; got_ar = 0;
            s_awready = 0; s_wready = 0; s_arready = 0; s_bvalid = 0; s_rvalid = 0;
         end else begin
            if (aw_fire) begin
               aw_fire = 0; s_awready = 0; got_aw = 1; n_aw++;
               chk_bit("R3", "awvalid drops after its handshake", m_awvalid, 1'b0);
            end
            if (w_fire) begin
               w_fire = 0; s_wready = 0; got_w = 1; n_w++;
               chk_bit("R3", "wvalid drops after its handshake", m_wvalid, 1'b0);
            end
            if (ar_fire) begin
               ar_fire = 0; s_arready = 0; got_ar = 1; n_ar++;
               chk_bit("R5", "arvalid drops after its handshake", m_arvalid, 1'b0);
            end
            if (b_fire) begin b_fire = 0; s_bvalid = 0; got_aw = 0; got_w = 0; end
            if (r_fire) begin r_fire = 0; s_rvalid = 0; got_ar = 0; end

            if (m_awvalid) begin
               chk_word("R3", "awaddr while valid", m_awaddr, exp_addr);
               if (aw_wait >= lat_aw) begin s_awready = 1; aw_wait = 0; end
               else aw_wait++;
            end
            if (m_wvalid) begin
               chk_word("R3", "wdata while valid", m_wdata, exp_wdata);
               chk_word("R3", "wstrb while valid", {28'd0, m_wstrb}, {28'd0, exp_strb});
               if (w_wait >= lat_w) begin s_wready = 1; w_wait = 0; end
               else w_wait++;
            end
            if (m_arvalid) begin
               chk_word("R5", "araddr while valid", m_araddr, exp_addr);
               if (ar_wait >= lat_aw) begin s_arready = 1; ar_wait = 0; end
               else ar_wait++;
            end
            if (got_aw && got_w && !s_bvalid) begin
               if (b_wait >= lat_b) begin s_bvalid = 1; s_bresp = cfg_resp; b_wait = 0; end
               else b_wait++;
            end
            if (got_ar && !s_rvalid) begin
               if (r_wait >= lat_r) begin
                  s_rvalid = 1; s_rresp = cfg_resp; s_rdata = cfg_rdata; r_wait = 0;
               end else r_wait++;
            end
            if (s_bvalid) chk_bit("R4", "bready while response offered", m_bready, 1'b1);
            if (s_rvalid) chk_bit("R5", "rready while data offered", m_rready, 1'b1);

            aw_fire = m_awvalid && s_awready;
            w_fire  = m_wvalid && s_wready;
            ar_fire = m_arvalid && s_arready;
            b_fire  = s_bvalid && m_bready;
            r_fire  = s_rvalid && m_rready;
         end
      end
   end

   // monitor: pops the scoreboard on each completion pulse
   initial begin
      bit prev_done;
      prev_done = 0;
      forever begin
         @(negedge clk);
         if (!rst_n) prev_done = 0;
         else begin
            if (done) begin
               if (prev_done) chk_bit("R4", "done lasts one cycle", 1'b1, 1'b0);
               else if (exp_q.size() == 0) chk_bit("R9", "done without pending request", 1'b1, 1'b0);
               else begin
                  exp_t e;
                  e = exp_q.pop_front();
                  if (e.is_rd) begin
                     chk_word("R5", "captured read data", rd_data, e.data);
                     chk_bit(e.resp == 2'b11 ? "R7" : "R6", "rd_err at done", rd_err, e.err);
                     chk_bit("R8", "wr_err clear on read", wr_err, 1'b0);
                  end else begin
                     chk_bit(e.resp == 2'b11 ? "R7" : "R6", "wr_err at done", wr_err, e.err);
                     chk_bit("R8", "rd_err clear on write", rd_err, 1'b0);
                  end
               end
            end
            prev_done = done;
         end
      end
   end

   task automatic run_txn(input bit rd, input bit wr, input logic [31:0] addr,
                          input logic [31:0] data, input logic [3:0] strb,
                          input logic [1:0] resp, input int la, input int lw,
                          input int lresp, input bit noise);
      exp_t e;
      int   aw0, w0, ar0;
      aw0 = n_aw; w0 = n_w; ar0 = n_ar;
      lat_aw = la; lat_w = lw; lat_b = lresp; lat_r = lresp;
      cfg_resp = resp; cfg_rdata = data;
      exp_addr = addr; exp_wdata = data; exp_strb = strb;
      e.is_rd = rd;
      e.data  = data;
      e.err   = resp[1];
      e.resp  = resp;
      exp_q.push_back(e);
      req_rd = rd; req_wr = wr; req_addr = addr; req_wdata = data; req_wstrb = strb;
      @(negedge clk);
      req_rd = 0; req_wr = 0;
      req_addr = ~addr; req_wdata = ~data; req_wstrb = ~strb;
      chk_bit("R8", "rd_err cleared on take", rd_err, 1'b0);
      chk_bit("R8", "wr_err cleared on take", wr_err, 1'b0);
      while (done !== 1'b1) begin
         if (noise) begin req_rd = 1; req_wr = 1; req_addr = $urandom; end
         @(negedge clk);
      end
      req_rd = 0; req_wr = 0;
      @(negedge clk);
      chk_bit("R10", "idle after done: no address valid", m_arvalid | m_awvalid, 1'b0);
      chk_int("R9", "read address transfers", n_ar - ar0, rd ? 1 : 0);
      chk_int(rd && wr ? "R2" : "R9", "write address transfers", n_aw - aw0, rd ? 0 : 1);
      chk_int("R9", "write data transfers", n_w - w0, rd ? 0 : 1);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      rst_n = 0; req_rd = 0; req_wr = 0; req_addr = '0; req_wdata = '0; req_wstrb = '0;
      lat_aw = 0; lat_w = 0; lat_b = 0; lat_r = 0; cfg_resp = 2'b00;
      cfg_rdata = '0; exp_addr = '0; exp_wdata = '0; exp_strb = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk_bit("R1", "awvalid in reset", m_awvalid, 1'b0);
      chk_bit("R1", "wvalid in reset", m_wvalid, 1'b0);
      chk_bit("R1", "arvalid in reset", m_arvalid, 1'b0);
      chk_bit("R1", "bready in reset", m_bready, 1'b0);
      chk_bit("R1", "rready in reset", m_rready, 1'b0);
      chk_bit("R1", "done in reset", done, 1'b0);
      chk_bit("R1", "errors in reset", rd_err | wr_err, 1'b0);
      chk_word("R1", "rd_data in reset", rd_data, 32'h0);
      rst_n = 1;
      @(negedge clk);

      // R3 R4 plain write, OKAY
      run_txn(0, 1, 32'h0000_0010, 32'hDEAD_BEEF, 4'hF, 2'b00, 0, 0, 0, 0);
      // R5 read with latency, OKAY
      run_txn(1, 0, 32'h0000_0024, 32'hA5A5_3C3C, 4'h0, 2'b00, 2, 0, 2, 0);
      // R3 independent drops: address fast, data slow
      run_txn(0, 1, 32'h0000_0100, 32'h1234_5678, 4'b0101, 2'b00, 0, 3, 1, 0);
      // R3 reverse: data fast, address slow
      run_txn(0, 1, 32'h0000_0104, 32'h0F0F_F0F0, 4'b1000, 2'b01, 4, 0, 0, 0);
      // R6 write SLVERR, then sticky check
      run_txn(0, 1, 32'hFFFF_0000, 32'h0000_0001, 4'h1, 2'b10, 1, 1, 1, 0);
      repeat (3) @(negedge clk);
      chk_bit("R8", "wr_err held while idle", wr_err, 1'b1);
      // R7 read DECERR, clears write error on take
      run_txn(1, 0, 32'hFFFF_0004, 32'h7777_8888, 4'h0, 2'b11, 0, 0, 0, 0);
      repeat (2) @(negedge clk);
      chk_bit("R8", "rd_err held while idle", rd_err, 1'b1);
      // R6 read SLVERR
      run_txn(1, 0, 32'hFFFF_0008, 32'h1111_2222, 4'h0, 2'b10, 1, 0, 3, 0);
      // R7 read EXOKAY is not an error
      run_txn(1, 0, 32'h0000_0030, 32'hCAFE_F00D, 4'h0, 2'b01, 0, 0, 1, 0);
      // R2 both requests in the same cycle
      run_txn(1, 1, 32'h0000_0040, 32'h5555_AAAA, 4'hF, 2'b00, 1, 0, 0, 0);
      // R9 request noise while busy, slow slave
      run_txn(0, 1, 32'h0000_0200, 32'h8000_0001, 4'b0011, 2'b00, 3, 2, 4, 1);
      run_txn(1, 0, 32'h0000_0204, 32'h0BAD_CAFE, 4'h0, 2'b00, 2, 0, 3, 1);
      // R7 write DECERR
      run_txn(0, 1, 32'h0000_0300, 32'h0000_00FF, 4'b0001, 2'b11, 0, 0, 0, 0);
      // R10 back-to-back request raised in the first idle cycle
      run_txn(1, 0, 32'h0000_0304, 32'h2468_ACE0, 4'h0, 2'b00, 0, 0, 0, 0);
      chk_word("R5", "rd_data holds after later cycles", rd_data, 32'h2468_ACE0);
      run_txn(0, 1, 32'h0000_0308, 32'h1357_9BDF, 4'b1100, 2'b00, 0, 0, 0, 0);
      chk_word("R5", "rd_data unchanged by write", rd_data, 32'h2468_ACE0);
      chk_int("R9", "scoreboard drained", exp_q.size(), 0);
      finish_run();
   end

endmodule